// File: doc/BRIEF.md
# Reference clock validity monitor

This block turns the quality alarms of a bank of reference clock inputs into one validity flag per input. An input counts as usable when it has no loss of signal, no inactivity alarm and no hard frequency alarm. A configuration bit can add a further condition: the input's low-rate edges must stay inside the noise window. The alarms come from upstream measurement logic and arrive as synchronous levels. The block registers the combined result, so every validity flag follows its alarms one clock later.

One input at a time feeds the main DPLL path, chosen by a select index. That input is held to a stricter rule. Its phase-lock alarm must also be clear. When ultra-fast switching is enabled, it must also have missed fewer consecutive cycles than a set limit. Each change in an input's validity, in either direction, sets a sticky change flag. When the main reference drops from valid to invalid and the selection has not moved, a sticky failure flag is set. The interrupt line is the OR of the enabled sticky flags. A fault pin can be routed to show the enabled main-reference failure, and it stays high until software clears that flag with a write-one-to-clear strobe.

Top module: `refclk_valid_mon`

## Requirements
- R1: A registered validity bit valid_o[i] is 1 one clock after inputs in which ref i has los_i, no_act_i and freq_hard_i all 0 (and, when noise_win_en is 1, noise_viol_i 0). Otherwise it is 0.
- R2: When noise_win_en is 0, noise_viol_i has no effect on any validity output.
- R3: main_valid_o is 1 one clock after the selected ref is valid per R1 and its phase_alarm_i bit is 0. A phase alarm on an unselected ref has no effect on main_valid_o or on valid_o.
- R4: When ultra_fast_en is 1 and miss_run is at or above MISS_LIMIT (default 2), main_valid_o is 0 one clock later. A miss_run below the limit, or any miss_run while ultra_fast_en is 0, has no effect.
- R5: Any change of valid_o[i] after the first post-reset update sets the sticky flag chg_o[i] in the same clock, for both falling and rising edges.
- R6: irq_o is 1 exactly when some chg_o[i] is 1 with chg_irq_en[i] set, or when fail_o is 1 with fail_irq_en set.
- R7: fail_o is set when main_valid_o goes from 1 to 0 while main_sel holds the same value as in the previous cycle. A drop caused by changing main_sel does not set it.
- R8: fault_o equals fault_route AND fail_o AND fail_irq_en. Once set, it stays high until fail_o is cleared.
- R9: A cycle with clr_we high clears each chg_o[i] whose clr_chg[i] is 1, and clears fail_o when clr_fail is 1. If a clear and a new event for the same flag fall in the same cycle, the flag stays set. Bits whose clear is 0 are unaffected.
- R10: During reset all outputs are 0. The first update after reset loads the validity bits without setting any change or failure flag.
- R11: A main_sel value of NUM_REFS or above makes main_valid_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| los_i | input | NUM_REFS | Loss-of-signal alarm per ref |
| no_act_i | input | NUM_REFS | No-activity alarm per ref |
| freq_hard_i | input | NUM_REFS | Hard frequency alarm per ref |
| noise_viol_i | input | NUM_REFS | Noise-window edge violation per ref |
| phase_alarm_i | input | NUM_REFS | Phase-lock alarm per ref |
| noise_win_en | input | 1 | Include noise-window check in validity |
| ultra_fast_en | input | 1 | Include missed-cycle check for main ref |
| main_sel | input | IDX_W | Index of the ref feeding the main path |
| miss_run | input | MISS_W | Consecutive missed cycles of the main ref |
| chg_irq_en | input | NUM_REFS | Interrupt enable per change flag |
| fail_irq_en | input | 1 | Interrupt enable for main-ref failure |
| fault_route | input | 1 | Route the failure interrupt to fault_o |
| clr_we | input | 1 | Clear strobe |
| clr_chg | input | NUM_REFS | Write-one-to-clear mask for change flags |
| clr_fail | input | 1 | Write-one-to-clear for failure flag |
| valid_o | output | NUM_REFS | Registered validity per ref |
| main_valid_o | output | 1 | Registered strict validity of main ref |
| chg_o | output | NUM_REFS | Sticky validity-change flags |
| fail_o | output | 1 | Sticky main-reference-failed flag |
| irq_o | output | 1 | Interrupt |
| fault_o | output | 1 | Level-held fault pin |

## Verification
The bench builds the block with its defaults: 14 refs, a 3-bit miss counter and a miss limit of 2. With these values it can select every index up to the highest real one (13) and the two unused codes above it, so the out-of-range select case is tested. The 3-bit counter lets the bench drive miss counts just below the limit, at the limit and at its maximum of 7, with ultra-fast switching both on and off.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef struct packed {
        logic los;
        logic no_act;
        logic freq_hard;
        logic noise;
    } ref_alarm_t;

    function automatic logic ref_ok(input ref_alarm_t a, input logic noise_en);
        return !(a.los || a.no_act || a.freq_hard || (noise_en && a.noise));
    endfunction

endpackage

// File: rtl/refmon_qual.sv
module refmon_qual
    import refmon_pkg::*;
#(
    parameter int NUM_REFS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                primed,
    input  logic [NUM_REFS-1:0] los,
    input  logic [NUM_REFS-1:0] no_act,
    input  logic [NUM_REFS-1:0] freq_hard,
    input  logic [NUM_REFS-1:0] noise,
    input  logic                noise_en,
    output logic [NUM_REFS-1:0] valid_next,
    output logic [NUM_REFS-1:0] valid_q,
    output logic [NUM_REFS-1:0] chg_evt
);

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
        ref_alarm_t a;
        assign a = '{los: los[g], no_act: no_act[g], freq_hard: freq_hard[g], noise: noise[g]};
        assign valid_next[g] = ref_ok(a, noise_en);

        always_ff @(posedge clk) begin
            if (rst) valid_q[g] <= 1'b0;
            else     valid_q[g] <= valid_next[g];
        end

        assign chg_evt[g] = primed && (valid_next[g] != valid_q[g]);

        // R1: any hard alarm forces invalid on the next clock
        p_alarm_invalid_r1: assert property (@(posedge clk) disable iff (rst)
            (los[g] || no_act[g] || freq_hard[g]) |=> !valid_q[g]);

        // R2: noise ignored when window disabled
        p_noise_ignored_r2: assert property (@(posedge clk) disable iff (rst)
            (!noise_en && !los[g] && !no_act[g] && !freq_hard[g]) |=> valid_q[g]);
    end

endmodule

// File: rtl/refmon_main.sv
module refmon_main #(
    parameter int NUM_REFS   = 14,
    parameter int IDX_W      = 4,
    parameter int MISS_W     = 3,
    parameter int MISS_LIMIT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                primed,
    input  logic [NUM_REFS-1:0] valid_next,
    input  logic [NUM_REFS-1:0] phase_alarm,
    input  logic [IDX_W-1:0]    main_sel,
    input  logic                ultra_fast_en,
    input  logic [MISS_W-1:0]   miss_run,
    output logic                main_valid_q,
    output logic                fail_evt
);

    localparam logic [MISS_W-1:0] LIMIT = MISS_W'(MISS_LIMIT);

    logic             sel_valid;
    logic             sel_phase;
    logic             sel_in_range;
    logic             miss_bad;
    logic             main_ok;
    logic [IDX_W-1:0] sel_q;

    always_comb begin
        sel_valid    = 1'b0;
        sel_phase    = 1'b0;
        sel_in_range = 1'b0;
        for (int j = 0; j < NUM_REFS; j++) begin
            if (main_sel == IDX_W'(j)) begin
                sel_valid    = valid_next[j];
                sel_phase    = phase_alarm[j];
                sel_in_range = 1'b1;
            end
        end
    end

    assign miss_bad = ultra_fast_en && (miss_run >= LIMIT);
    assign main_ok  = sel_in_range && sel_valid && !sel_phase && !miss_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_valid_q <= 1'b0;
            sel_q        <= '0;
        end else begin
            main_valid_q <= main_ok;
            sel_q        <= main_sel;
        end
    end

    assign fail_evt = primed && main_valid_q && !main_ok && (main_sel == sel_q);

    // R3: phase alarm on the selected ref blocks main validity
    p_phase_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        sel_phase |=> !main_valid_q);

    // R4: too many missed cycles with ultra-fast switching
    p_miss_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (ultra_fast_en && miss_run >= LIMIT) |=> !main_valid_q);

    // R11: out-of-range select is never valid
    p_range_r11: assert property (@(posedge clk) disable iff (rst)
        !sel_in_range |=> !main_valid_q);

endmodule

// File: rtl/refmon_sticky.sv
module refmon_sticky #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flag
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) flag[g] <= 1'b0;
            else     flag[g] <= (flag[g] && !clr[g]) || set[g];
        end

        // R9: a new event wins over a same-cycle clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> flag[g]);
    end

endmodule

// File: rtl/refclk_valid_mon.sv
module refclk_valid_mon #(
    parameter int NUM_REFS   = 14,
    parameter int MISS_W     = 3,
    parameter int MISS_LIMIT = 2,
    localparam int IDX_W     = $clog2(NUM_REFS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REFS-1:0] los_i,
    input  logic [NUM_REFS-1:0] no_act_i,
    input  logic [NUM_REFS-1:0] freq_hard_i,
    input  logic [NUM_REFS-1:0] noise_viol_i,
    input  logic [NUM_REFS-1:0] phase_alarm_i,
    input  logic                noise_win_en,
    input  logic                ultra_fast_en,
    input  logic [IDX_W-1:0]    main_sel,
    input  logic [MISS_W-1:0]   miss_run,
    input  logic [NUM_REFS-1:0] chg_irq_en,
    input  logic                fail_irq_en,
    input  logic                fault_route,
    input  logic                clr_we,
    input  logic [NUM_REFS-1:0] clr_chg,
    input  logic                clr_fail,
    output logic [NUM_REFS-1:0] valid_o,
    output logic                main_valid_o,
    output logic [NUM_REFS-1:0] chg_o,
    output logic                fail_o,
    output logic                irq_o,
    output logic                fault_o
);

    logic                primed;
    logic [NUM_REFS-1:0] valid_next;
    logic [NUM_REFS-1:0] chg_evt;
    logic                fail_evt;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    refmon_qual #(.NUM_REFS(NUM_REFS)) u_qual (
        .clk(clk), .rst(rst), .primed(primed),
        .los(los_i), .no_act(no_act_i), .freq_hard(freq_hard_i), .noise(noise_viol_i),
        .noise_en(noise_win_en),
        .valid_next(valid_next), .valid_q(valid_o), .chg_evt(chg_evt)
    );

    refmon_main #(
        .NUM_REFS(NUM_REFS), .IDX_W(IDX_W), .MISS_W(MISS_W), .MISS_LIMIT(MISS_LIMIT)
    ) u_main (
        .clk(clk), .rst(rst), .primed(primed),
        .valid_next(valid_next), .phase_alarm(phase_alarm_i),
        .main_sel(main_sel), .ultra_fast_en(ultra_fast_en), .miss_run(miss_run),
        .main_valid_q(main_valid_o), .fail_evt(fail_evt)
    );

    refmon_sticky #(.W(NUM_REFS)) u_chg (
        .clk(clk), .rst(rst), .set(chg_evt),
        .clr(clr_we ? clr_chg : '0), .flag(chg_o)
    );

    refmon_sticky #(.W(1)) u_fail (
        .clk(clk), .rst(rst), .set(fail_evt),
        .clr(clr_we && clr_fail), .flag(fail_o)
    );

    assign irq_o   = (|(chg_o & chg_irq_en)) || (fail_o && fail_irq_en);
    assign fault_o = fault_route && fail_o && fail_irq_en;

    // R7: a reselection never raises the failure flag
    p_reselect_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (primed && main_sel != $past(main_sel) && !fail_o) |=> !fail_o);

    // R8: fault stays high until the failure flag is cleared
    p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !(clr_we && clr_fail)) |=> (fault_o || !fault_route || !fail_irq_en));

    // R10: reset leaves every flag clear
    p_reset_clean_r10: assert property (@(posedge clk)
        rst |=> (chg_o == '0 && !fail_o && valid_o == '0 && !main_valid_o));

endmodule

// File: tb/sim_refclk_valid_mon.sv
module sim_refclk_valid_mon;

    localparam int N = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] los_i = '0, no_act_i = '0, freq_hard_i = '0, noise_viol_i = '0, phase_alarm_i = '0;
    logic noise_win_en = 1'b0, ultra_fast_en = 1'b0;
    logic [3:0] main_sel = 4'd0;
    logic [2:0] miss_run = 3'd0;
    logic [N-1:0] chg_irq_en = '0;
    logic fail_irq_en = 1'b0, fault_route = 1'b0, clr_we = 1'b0, clr_fail = 1'b0;
    logic [N-1:0] clr_chg = '0;
    logic [N-1:0] valid_o, chg_o;
    logic main_valid_o, fail_o, irq_o, fault_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    refclk_valid_mon u0 (
        .clk(clk), .rst(rst), .los_i(los_i), .no_act_i(no_act_i), .freq_hard_i(freq_hard_i),
        .noise_viol_i(noise_viol_i), .phase_alarm_i(phase_alarm_i),
        .noise_win_en(noise_win_en), .ultra_fast_en(ultra_fast_en), .main_sel(main_sel),
        .miss_run(miss_run), .chg_irq_en(chg_irq_en), .fail_irq_en(fail_irq_en),
        .fault_route(fault_route), .clr_we(clr_we), .clr_chg(clr_chg), .clr_fail(clr_fail),
        .valid_o(valid_o), .main_valid_o(main_valid_o), .chg_o(chg_o), .fail_o(fail_o),
        .irq_o(irq_o), .fault_o(fault_o)
    );

    typedef struct packed {
        logic [N-1:0] los, noact, freq, noise, phase;
        logic         nen, ufs;
        logic [3:0]   sel;
        logic [2:0]   miss;
        logic [N-1:0] exp_valid;
        logic         exp_main;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b0, 4'd3,  3'd0, 14'h3FFF, 1'b1},
        '{14'h0001, 14'h0002, 14'h0004, 14'h0008, 14'h0000, 1'b0, 1'b0, 4'd3,  3'd0, 14'h3FF8, 1'b1},
        '{14'h0001, 14'h0002, 14'h0004, 14'h0008, 14'h0000, 1'b1, 1'b0, 4'd3,  3'd0, 14'h3FF0, 1'b0},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0010, 1'b0, 1'b0, 4'd4,  3'd0, 14'h3FFF, 1'b0},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0010, 1'b0, 1'b0, 4'd5,  3'd0, 14'h3FFF, 1'b1},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b1, 4'd5,  3'd1, 14'h3FFF, 1'b1},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b1, 4'd5,  3'd2, 14'h3FFF, 1'b0},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b0, 4'd5,  3'd7, 14'h3FFF, 1'b1},
        '{14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 1'b0, 1'b0, 4'd14, 3'd0, 14'h3FFF, 1'b0},
        '{14'h0000, 14'h0000, 14'h0000, 14'h2000, 14'h0000, 1'b1, 1'b0, 4'd13, 3'd0, 14'h1FFF, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_chg = '1; clr_fail = 1'b1;
        step();
        clr_we = 1'b0; clr_chg = '0; clr_fail = 1'b0;
    endtask

    task automatic clean_inputs();
        los_i = '0; no_act_i = '0; freq_hard_i = '0; noise_viol_i = '0; phase_alarm_i = '0;
        noise_win_en = 1'b0; ultra_fast_en = 1'b0; miss_run = 3'd0; main_sel = 4'd3;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R10: reset state
        chk("R10 reset valid", 32'(valid_o), 0);
        chk("R10 reset flags", {chg_o, fail_o, irq_o, fault_o, main_valid_o}, 0);
        rst = 1'b0;
        step();
        chk("R10 first load valid", 32'(valid_o), 32'h3FFF);
        chk("R10 first load no chg", 32'(chg_o), 0);
        chk("R10 first load no fail", 32'(fail_o), 0);

        // Table walk: R1 R2 R3 R4 R11
        for (int k = 0; k < NV; k++) begin
            los_i = TBL[k].los; no_act_i = TBL[k].noact; freq_hard_i = TBL[k].freq;
            noise_viol_i = TBL[k].noise; phase_alarm_i = TBL[k].phase;
            noise_win_en = TBL[k].nen; ultra_fast_en = TBL[k].ufs;
            main_sel = TBL[k].sel; miss_run = TBL[k].miss;
            step();
            chk($sformatf("R1 R2 valid vec%0d", k), 32'(valid_o), 32'(TBL[k].exp_valid));
            chk($sformatf("R3 R4 R11 main vec%0d", k), 32'(main_valid_o), 32'(TBL[k].exp_main));
        end

        clean_inputs();
        step();
        clear_all();
        chk("R9 clear all chg", 32'(chg_o), 0);
        chk("R9 clear all fail", 32'(fail_o), 0);

        // R5: falling and rising changes set sticky flag
        los_i[2] = 1'b1;
        step();
        chk("R5 falling sets chg", 32'(chg_o), 32'h0004);
        // R6: interrupt gating
        chg_irq_en = 14'h0004; #1;
        chk("R6 irq enabled", 32'(irq_o), 1);
        chg_irq_en = 14'h0008; #1;
        chk("R6 irq masked", 32'(irq_o), 0);
        chg_irq_en = '0;
        // R9: clear of an unset bit does nothing to others
        clr_we = 1'b1; clr_chg = 14'h0020;
        step();
        clr_we = 1'b0; clr_chg = '0;
        chk("R9 unrelated clear", 32'(chg_o), 32'h0004);
        clr_we = 1'b1; clr_chg = 14'h0004;
        step();
        clr_we = 1'b0; clr_chg = '0;
        chk("R9 clear bit", 32'(chg_o), 0);
        los_i[2] = 1'b0;
        step();
        chk("R5 rising sets chg", 32'(chg_o), 32'h0004);
        // R9: same-cycle clear and event keeps set
        los_i[2] = 1'b1; clr_we = 1'b1; clr_chg = 14'h0004;
        step();
        clr_we = 1'b0; clr_chg = '0;
        chk("R9 set wins", 32'(chg_o), 32'h0004);
        los_i[2] = 1'b0;
        step();
        clear_all();

        // R7: failure on drop with stable selection
        los_i[3] = 1'b1;
        step();
        chk("R7 main dropped", 32'(main_valid_o), 0);
        chk("R7 fail set", 32'(fail_o), 1);
        clear_all();
        los_i[3] = 1'b0;
        step();
        chk("R7 main back", 32'(main_valid_o), 1);
        los_i[0] = 1'b1; main_sel = 4'd0;
        step();
        chk("R7 reselect drop main", 32'(main_valid_o), 0);
        chk("R7 reselect no fail", 32'(fail_o), 0);
        los_i[0] = 1'b0; main_sel = 4'd3;
        step();
        clear_all();

        // R8: fault pin held until cleared
        fault_route = 1'b1; fail_irq_en = 1'b1;
        los_i[3] = 1'b1;
        step();
        chk("R8 fault set", 32'(fault_o), 1);
        chk("R6 fail irq", 32'(irq_o), 1);
        los_i[3] = 1'b0;
        repeat (3) step();
        chk("R8 fault held", 32'(fault_o), 1);
        clr_we = 1'b1; clr_fail = 1'b1;
        step();
        clr_we = 1'b0; clr_fail = 1'b0;
        chk("R8 fault cleared", 32'(fault_o), 0);
        chk("R6 irq off after clear", 32'(irq_o), 0);
        fault_route = 1'b0;
        los_i[3] = 1'b1;
        step();
        chk("R8 fail set unrouted", 32'(fail_o), 1);
        chk("R8 fault unrouted", 32'(fault_o), 0);
        chk("R6 irq unrouted", 32'(irq_o), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule